// File: doc/BRIEF.md
# Local interrupt priority arbiter

This block keeps three 256-bit vector sets for one processor: the vectors waiting for service, the vectors the core is servicing, and the trigger kind (level or edge) last recorded for each vector. From these and a programmable task priority it works out which vector may be presented to the core. It drives a registered request line and answers the core's acknowledge with either a real vector or the programmed spurious vector.

Priority works on classes of sixteen vectors, given by the upper four bits of the vector number. A vector being serviced raises the effective processor priority to its own class, so vectors of that class and below wait. When the core retires a vector with an end-of-interrupt strobe, a level-triggered vector produces a broadcast pulse so that the source can re-sample its line. A directed mode bit turns the broadcast off.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A set strobe marks its vector pending and records its trigger kind (set_level 1 = level, 0 = edge). A later set of the same vector overwrites the recorded kind.
- R2: Among pending vectors, the one with the highest number is the candidate. This holds across all eight 32-bit words.
- R3: ppr equals the task priority when the task priority's upper nibble is at least the class of the highest in-service vector. Otherwise ppr is that class followed by four zero bits. An empty in-service set counts as class 0.
- R4: When ppr is nonzero, the candidate is deliverable only if its class is strictly above ppr's upper nibble; with ppr zero any candidate is deliverable. irq is registered and reflects the state one cycle after any change.
- R5: While the enable bit (bit 8) of the spurious register is 0, irq stays 0 and every acknowledge returns the spurious vector.
- R6: A spurious-register write stores bits 12 and 8:0. Bits 7:0 form the spurious vector.
- R7: An acknowledge of a deliverable candidate moves it from pending to in-service. It returns the vector on ack_vector with ack_valid one cycle after ack_req.
- R8: An acknowledge with no deliverable candidate returns the spurious vector and leaves all state unchanged.
- R9: An end-of-interrupt retires the highest in-service vector. With nothing in service it has no effect.
- R10: When the retired vector is level-triggered and bit 12 of the spurious register is 0, eoi_bc_valid pulses one cycle after the strobe with the vector on eoi_bc_vector. No pulse is given for an edge vector or while bit 12 is 1.
- R11: Reset clears all three vector sets and the task priority, sets the spurious register to 0x0FF, and drives irq, ack_valid and eoi_bc_valid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_valid | input | 1 | Vector-set strobe |
| set_vector | input | 8 | Vector to mark pending |
| set_level | input | 1 | Trigger kind of the set vector, 1 = level |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority value |
| svr_we | input | 1 | Spurious-register write strobe |
| svr_wdata | input | 13 | Spurious-register value (bit 12 directed, bit 8 enable, 7:0 vector) |
| ack_req | input | 1 | Core acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_vector | output | 8 | Acknowledged or spurious vector |
| ppr | output | 8 | Processor priority |
| eoi_bc_valid | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bc_vector | output | 8 | Vector retired by the broadcast |

## Verification
The hardest situation to reach is an acknowledge that arrives while a vector is pending but blocked by priority. The spurious answer must then come back with the pending set and the in-service set both left alone. The stimulus gets there by putting a vector in service and leaving a lower one of the same or a lower class pending, or by raising the task priority above the pending class. It then reads back the untouched state through ppr, irq and later acknowledges. Retiring a vector whose trigger kind was overwritten from level to edge checks that the broadcast follows the last recorded kind.

// File: rtl/irqarb_pkg.sv
// Shared constants for the interrupt priority arbiter.
// Assumes the spurious register layout: bit 12 directed mode, bit 8 enable,
// bits 7:0 spurious vector.
package irqarb_pkg;
    localparam int SVR_W       = 13;
    localparam int SVR_EN_BIT  = 8;
    localparam int SVR_DIR_BIT = 12;
    localparam logic [SVR_W-1:0] SVR_KEEP  = 13'h11FF;
    localparam logic [SVR_W-1:0] SVR_RESET = 13'h00FF;
endpackage

// File: rtl/irqarb_find_top.sv
// Highest-set-bit finder over N bits, built as a two-level search:
// each W-bit word finds its own top bit, then the highest non-empty word wins.
// Assumes N is a multiple of W and W is a power of two.
module irqarb_find_top #(
    parameter int N = 256,
    parameter int W = 32
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int G  = N / W;
    localparam int GW = $clog2(W);
    localparam int IW = $clog2(N);

    logic [G-1:0]         grp_any;
    logic [G-1:0][GW-1:0] grp_idx;

    // Index of the highest set bit inside one word.
    function automatic logic [GW-1:0] word_top(input logic [W-1:0] w);
        logic [GW-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            if (w[i]) r = GW'(i);
        end
        return r;
    endfunction

    genvar g;
    generate
        for (g = 0; g < G; g++) begin : gen_word
            assign grp_any[g] = |bits[g*W +: W];
            assign grp_idx[g] = word_top(bits[g*W +: W]);
        end
    endgenerate

    // Second level: the highest word with any bit set supplies the result.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < G; k++) begin
            if (grp_any[k]) begin
                any = 1'b1;
                idx = IW'(k * W) + IW'(grp_idx[k]);
            end
        end
    end
endmodule

// File: rtl/irqarb_vec_bank.sv
// One N-bit vector set with a single-bit set port and a single-bit clear port.
// Assumes a set and a clear of the same bit in one cycle leaves the bit set.
module irqarb_vec_bank #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  bits
);
    // Bit storage; the later set assignment takes precedence over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            if (clr_en) bits[clr_idx] <= 1'b0;
            if (set_en) bits[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/irqarb_prio.sv
// Processor-priority and delivery decision, purely combinational.
// Assumes the class of a vector is its upper CLASS_W bits.
module irqarb_prio #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_any,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             pend_any,
    input  logic [VEC_W-1:0] pend_top,
    input  logic             enable,
    output logic [VEC_W-1:0] ppr,
    output logic             deliver
);
    localparam int LOW_W = VEC_W - CLASS_W;

    logic [CLASS_W-1:0] isr_cls, tpr_cls, pend_cls;

    // Processor priority from task priority and the top in-service class.
    always_comb begin
        isr_cls = isr_any ? isr_top[VEC_W-1 -: CLASS_W] : '0;
        tpr_cls = tpr[VEC_W-1 -: CLASS_W];
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {LOW_W{1'b0}}};
    end

    // Candidate may go out only above the current priority class.
    always_comb begin
        pend_cls = pend_top[VEC_W-1 -: CLASS_W];
        deliver  = enable && pend_any &&
                   !((ppr != '0) && (pend_cls <= ppr[VEC_W-1 -: CLASS_W]));
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
// Local interrupt priority arbiter: pending, in-service and trigger sets,
// task and spurious registers, request line, acknowledge and retire logic.
// Assumes single-cycle strobes from the core; all outputs except ppr are
// registered.
module irq_prio_arbiter
    import irqarb_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int WORD_W  = 32,
    parameter int CLASS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [VEC_W-1:0] set_vector,
    input  logic             set_level,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_we,
    input  logic [SVR_W-1:0] svr_wdata,
    input  logic             ack_req,
    input  logic             eoi,
    output logic             irq,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_bc_valid,
    output logic [VEC_W-1:0] eoi_bc_vector
);
    localparam int NUM_VEC = 1 << VEC_W;

    logic [NUM_VEC-1:0] pend_bits, isr_bits, tmr_bits;
    logic               pend_any, isr_any, deliver;
    logic [VEC_W-1:0]   pend_top, isr_top, ppr_c;
    logic [VEC_W-1:0]   tpr_q;
    logic [SVR_W-1:0]   svr_q;
    logic               ack_take, eoi_take;

    assign ack_take = ack_req && deliver;
    assign eoi_take = eoi && isr_any;

    irqarb_vec_bank #(.N(NUM_VEC), .IW(VEC_W)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_valid), .set_idx(set_vector),
        .clr_en(ack_take),  .clr_idx(pend_top),
        .bits(pend_bits)
    );

    irqarb_vec_bank #(.N(NUM_VEC), .IW(VEC_W)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_en(ack_take), .set_idx(pend_top),
        .clr_en(eoi_take), .clr_idx(isr_top),
        .bits(isr_bits)
    );

    irqarb_vec_bank #(.N(NUM_VEC), .IW(VEC_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_valid && set_level),  .set_idx(set_vector),
        .clr_en(set_valid && !set_level), .clr_idx(set_vector),
        .bits(tmr_bits)
    );

    irqarb_find_top #(.N(NUM_VEC), .W(WORD_W)) u_pend_top (
        .bits(pend_bits), .any(pend_any), .idx(pend_top)
    );

    irqarb_find_top #(.N(NUM_VEC), .W(WORD_W)) u_isr_top (
        .bits(isr_bits), .any(isr_any), .idx(isr_top)
    );

    irqarb_prio #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
        .tpr(tpr_q), .isr_any(isr_any), .isr_top(isr_top),
        .pend_any(pend_any), .pend_top(pend_top),
        .enable(svr_q[SVR_EN_BIT]),
        .ppr(ppr_c), .deliver(deliver)
    );

    assign ppr = ppr_c;

    // Task and spurious registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= SVR_RESET;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata & SVR_KEEP;
        end
    end

    // Registered request line and acknowledge answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq        <= 1'b0;
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            irq       <= deliver;
            ack_valid <= ack_req;
            if (ack_req) ack_vector <= ack_take ? pend_top : svr_q[VEC_W-1:0];
        end
    end

    // Broadcast pulse for a retired level-triggered vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bc_valid  <= 1'b0;
            eoi_bc_vector <= '0;
        end else begin
            eoi_bc_valid <= eoi_take && tmr_bits[isr_top] && !svr_q[SVR_DIR_BIT];
            if (eoi_take) eoi_bc_vector <= isr_top;
        end
    end
endmodule

// File: rtl/irqarb_checker.sv
// Temporal checks on the arbiter, attached by bind.
module irqarb_checker
    import irqarb_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             ack_req,
    input logic             ack_valid,
    input logic             eoi,
    input logic             eoi_bc_valid,
    input logic [VEC_W-1:0] ppr,
    input logic [VEC_W-1:0] tpr_q,
    input logic [SVR_W-1:0] svr_q
);
    p_disabled_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !svr_q[SVR_EN_BIT] |=> !irq);

    p_ppr_not_below_tpr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    p_ack_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ack_req));

    p_bc_after_eoi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> $past(eoi));

    p_bc_not_directed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> !$past(svr_q[SVR_DIR_BIT]));

    p_irq_was_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(svr_q[SVR_EN_BIT]));
endmodule

bind irq_prio_arbiter irqarb_checker #(.VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .ack_req(ack_req),
    .ack_valid(ack_valid), .eoi(eoi), .eoi_bc_valid(eoi_bc_valid),
    .ppr(ppr), .tpr_q(tpr_q), .svr_q(svr_q)
);

// File: tb/tb_irq_prio_arbiter.sv
// Scoreboard bench: driver tasks queue expected acknowledge and broadcast
// vectors, a monitor pops and compares them as the outputs appear.
module tb_irq_prio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0;
    logic [7:0]  set_vector = '0;
    logic        set_level = 1'b0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [12:0] svr_wdata = '0;
    logic        ack_req = 1'b0;
    logic        eoi = 1'b0;
    logic        irq, ack_valid, eoi_bc_valid;
    logic [7:0]  ack_vector, ppr, eoi_bc_vector;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ack_exp_q[$];
    logic [7:0] bc_exp_q[$];

    always #2 clk = ~clk;

    irq_prio_arbiter dut (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_vector(set_vector), .set_level(set_level),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata),
        .ack_req(ack_req), .eoi(eoi),
        .irq(irq), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .ppr(ppr), .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vector(eoi_bc_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: compare every acknowledge and broadcast with the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_valid) begin
                if (ack_exp_q.size() == 0) chk("R7 unexpected ack", {24'd0, ack_vector}, 32'hFFFF);
                else chk("R7/R8 ack vector", {24'd0, ack_vector}, {24'd0, ack_exp_q.pop_front()});
            end
            if (eoi_bc_valid) begin
                if (bc_exp_q.size() == 0) chk("R10 unexpected broadcast", {24'd0, eoi_bc_vector}, 32'hFFFF);
                else chk("R10 broadcast vector", {24'd0, eoi_bc_vector}, {24'd0, bc_exp_q.pop_front()});
            end
        end
    end

    task automatic set_vec(input logic [7:0] v, input logic lvl);
        set_valid = 1'b1; set_vector = v; set_level = lvl;
        @(negedge clk); set_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_svr(input logic [12:0] v);
        svr_we = 1'b1; svr_wdata = v;
        @(negedge clk); svr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_ack(input logic [7:0] exp);
        ack_exp_q.push_back(exp);
        ack_req = 1'b1;
        @(negedge clk); ack_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_eoi(input logic exp_bc, input logic [7:0] v);
        if (exp_bc) bc_exp_q.push_back(v);
        eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 irq", {31'd0, irq}, 0);
        chk("R11 ppr", {24'd0, ppr}, 0);
        chk("R11 ack_valid", {31'd0, ack_valid}, 0);
        chk("R11 bc_valid", {31'd0, eoi_bc_valid}, 0);

        // R5: disabled after reset, spurious 0xFF answers
        set_vec(8'h40, 1'b0);
        chk("R5 irq disabled", {31'd0, irq}, 0);
        do_ack(8'hFF);
        chk("R5 irq still off", {31'd0, irq}, 0);
        wr_svr(13'h01FF);
        chk("R4 irq after enable", {31'd0, irq}, 1);

        // R7, R3, R4, R8
        set_vec(8'h41, 1'b1);
        set_vec(8'h35, 1'b0);
        do_ack(8'h41);
        chk("R3 ppr from isr", {24'd0, ppr}, 32'h40);
        chk("R4 same class blocked", {31'd0, irq}, 0);
        do_ack(8'hFF);
        chk("R8 ppr unchanged", {24'd0, ppr}, 32'h40);
        do_eoi(1'b1, 8'h41);
        chk("R9 ppr after retire", {24'd0, ppr}, 0);
        chk("R8 pending kept", {31'd0, irq}, 1);
        do_ack(8'h40);
        do_ack(8'hFF);
        do_eoi(1'b0, 8'h40);
        do_ack(8'h35);
        chk("R3 ppr class 3", {24'd0, ppr}, 32'h30);
        do_eoi(1'b0, 8'h35);
        do_eoi(1'b0, 8'h00);
        chk("R9 empty retire", {24'd0, ppr}, 0);
        chk("R9 nothing pending", {31'd0, irq}, 0);

        // R3/R4 with task priority
        wr_tpr(8'h50);
        chk("R3 ppr from tpr", {24'd0, ppr}, 32'h50);
        set_vec(8'h55, 1'b0);
        chk("R4 equal class blocked", {31'd0, irq}, 0);
        set_vec(8'h60, 1'b0);
        chk("R4 higher class delivered", {31'd0, irq}, 1);
        do_ack(8'h60);
        chk("R3 isr above tpr", {24'd0, ppr}, 32'h60);
        wr_tpr(8'h70);
        chk("R3 tpr above isr", {24'd0, ppr}, 32'h70);
        do_eoi(1'b0, 8'h60);
        chk("R9 ppr tpr only", {24'd0, ppr}, 32'h70);
        do_ack(8'hFF);
        wr_tpr(8'h05);
        chk("R3 low tpr", {24'd0, ppr}, 32'h05);
        chk("R4 class 5 over nonzero ppr", {31'd0, irq}, 1);
        do_ack(8'h55);
        chk("R3 ppr 0x50", {24'd0, ppr}, 32'h50);
        do_eoi(1'b0, 8'h55);
        wr_tpr(8'h00);

        // R10 directed mode suppresses broadcast
        wr_svr(13'h11FF);
        set_vec(8'h80, 1'b1);
        do_ack(8'h80);
        do_eoi(1'b0, 8'h80);
        wr_svr(13'h01FF);

        // R1 trigger kind overwrite
        set_vec(8'h90, 1'b1);
        set_vec(8'h90, 1'b0);
        do_ack(8'h90);
        do_eoi(1'b0, 8'h90);
        set_vec(8'h91, 1'b1);
        do_ack(8'h91);
        do_eoi(1'b1, 8'h91);

        // R2 search across words; ppr zero rule
        set_vec(8'h03, 1'b0);
        set_vec(8'hFE, 1'b0);
        set_vec(8'h21, 1'b0);
        do_ack(8'hFE);
        do_ack(8'hFF);
        do_eoi(1'b0, 8'hFE);
        do_ack(8'h21);
        do_eoi(1'b0, 8'h21);
        do_ack(8'h03);
        chk("R3 class 0 in service", {24'd0, ppr}, 0);
        do_eoi(1'b0, 8'h03);

        // R6 spurious vector field
        wr_svr(13'h01A5);
        do_ack(8'hA5);
        chk("R6 nothing pending", {31'd0, irq}, 0);
        wr_svr(13'h00A5);
        set_vec(8'h22, 1'b0);
        chk("R5 disabled with pending", {31'd0, irq}, 0);
        do_ack(8'hA5);

        @(negedge clk);
        chk("R7 all acks seen", ack_exp_q.size(), 0);
        chk("R10 all broadcasts seen", bc_exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule